// File: doc/BRIEF.md
# Interrupt-Triggered Chained Transfer Sequencer

The sequencer moves data on behalf of peripheral interrupt lines, so the CPU does not have to. Forty request lines each have an enable bit. The enable bits sit in five byte-wide banks that software loads. A request on an enabled line is latched as pending.

When the sequencer is idle it takes the lowest-numbered pending and enabled line. It first reads that line's vector word, which names a control record. It then runs the record: it reads both words of the record, copies one data word from the record's source address to its destination address, and writes the record's first word back with an updated counter. If the record's chain flag is set, the next record is run in the same way without returning to idle.

When the chain ends, only the first record decides the outcome. If its counter passed through its terminal step, the sequencer clears the line's enable bit and pulses the CPU interrupt. In repeat mode this also requires the record's interrupt-enable flag.

All vector, record and data accesses share one synchronous memory port with a request/acknowledge handshake.

Top module: `xfer_chain_seq`

## Requirements
- R1: After reset all 40 enable bits are 0. A cycle with `cfg_we` high loads `cfg_data` into bank `cfg_bank`, which holds enable bits 8*`cfg_bank` to 8*`cfg_bank`+7, and the new value appears on `en_q` in the following cycle.
- R2: A pulse on `src_req[k]` while enable bit k is 0 is ignored: it causes no memory access, `busy` stays 0, and no interrupt is raised.
- R3: When several enabled lines are pending, the lowest-numbered one is serviced first. One activation finishes, and `busy` returns to 0, before the next begins.
- R4: An activation of line s performs these accesses in order:
  - a read of the vector word at VEC_BASE+s, whose bits [4:0] give the record index i;
  - a read of record word 0 at REC_BASE+2i and of record word 1 at REC_BASE+2i+1;
  - a read of the data word at word1[11:0];
  - a write of that data word to word1[27:16];
  - a write-back of word 0 to REC_BASE+2i.
- R5: If bit 31 (chain) of the written-back word 0 is 1, the sequencer continues with record i+1 and `busy` stays 1 throughout. The activation ends only after the write-back of a record whose chain bit is 0.
- R6: The counter is word0[7:0] and the write-back changes only these bits:
  - a counter of 1 becomes 0 in normal mode (bit 29 = 0);
  - a counter of 1 becomes the reload field word0[15:8] in repeat mode (bit 29 = 1);
  - any other value decrements by one, with 0 wrapping to 255.
- R7: In normal mode, if the first record of the activation has counter 1, the line's enable bit is 0 from the cycle after the final write-back is acknowledged. `cpu_irq` is 1 for exactly that one cycle.
- R8: In repeat mode, the first record's counter of 1 clears the enable bit and raises `cpu_irq` only when bit 30 (repeat interrupt enable) is 1. Otherwise the enable bit stays set and no interrupt is raised.
- R9: Records reached through the chain flag never clear an enable bit or raise `cpu_irq`, whatever their counters do. `cpu_irq` stays 0 at all other times.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Enable bank write strobe |
| cfg_bank | input | 3 | Enable bank select |
| cfg_data | input | 8 | Enable bank write data |
| src_req | input | 40 | Peripheral request lines, one per source |
| en_q | output | 40 | Current enable bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the access in that cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| busy | output | 1 | An activation is in progress |
| cpu_irq | output | 1 | One-cycle interrupt request to the CPU |

## Verification
The assertions take for granted the following about the block's inputs:
- `mem_ack` arrives only while `mem_req` is high;
- software does not write an enable bank while an activation that may clear one of its bits is finishing;
- every vector names a valid record, and no chain runs past record 23.

The stimulus keeps to these rules. It acknowledges a request only after a latency that rotates through 0, 1 and 2 cycles, and drops the acknowledge for at least one cycle after each access. It reprograms enables and memory only while the sequencer is idle. It places vectors, records and data regions so that no access runs outside the programmed records or overlaps another region.

// File: rtl/xcs_pkg.sv
// Package: shared state encoding and control-record field positions for the
// chained transfer sequencer. Assumes a 32-bit memory word.
package xcs_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_LSB   = 0;   // counter, 8 bits
    localparam int RLD_LSB   = 8;   // reload value, 8 bits
    localparam int F_REPEAT  = 29;  // repeat mode
    localparam int F_RPTIRQ  = 30;  // repeat interrupt enable
    localparam int F_CHAIN   = 31;  // chain to next record
    localparam int DST_LSB   = 16;  // destination field in word 1

    typedef enum logic [2:0] {
        ST_IDLE, ST_VEC, ST_CD0, ST_CD1, ST_DRD, ST_DWR, ST_WB
    } xcs_state_e;
endpackage

// File: rtl/xcs_src_sel.sv
// Module: enable bank file, pending latches and lowest-index selection.
// Assumes clr_src is a valid source index whenever clr_vld is high.
module xcs_src_sel #(
    parameter int BANKS  = 5,
    parameter int BANK_W = 8,
    localparam int NSRC   = BANKS * BANK_W,
    localparam int SRC_W  = $clog2(NSRC),
    localparam int BSEL_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BSEL_W-1:0] cfg_bank,
    input  logic [BANK_W-1:0] cfg_data,
    input  logic [NSRC-1:0]   src_req,
    input  logic              take,
    input  logic              clr_vld,
    input  logic [SRC_W-1:0]  clr_src,
    output logic [NSRC-1:0]   en_q,
    output logic              pick_vld,
    output logic [SRC_W-1:0]  pick_idx
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] take_mask;
    logic [NSRC-1:0] eligible;

    // Decode the hardware clear and the service grant into masks.
    always_comb begin
        clr_mask  = clr_vld ? (NSRC'(1) << clr_src) : '0;
        take_mask = take ? (NSRC'(1) << pick_idx) : '0;
        eligible  = pend_q & en_q;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Per-bank enable register: software load, then hardware clear wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[b*BANK_W +: BANK_W] <= '0;
            else if (cfg_we && cfg_bank == BSEL_W'(b))
                en_q[b*BANK_W +: BANK_W] <= cfg_data & ~clr_mask[b*BANK_W +: BANK_W];
            else
                en_q[b*BANK_W +: BANK_W] <= en_q[b*BANK_W +: BANK_W] & ~clr_mask[b*BANK_W +: BANK_W];
        end
    end

    // Pending latches: set by enabled requests, dropped when serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~take_mask) | (src_req & en_q);
    end

    // Lowest-numbered eligible source wins.
    always_comb begin
        pick_vld = |eligible;
        pick_idx = '0;
        for (int k = NSRC - 1; k >= 0; k--)
            if (eligible[k]) pick_idx = SRC_W'(k);
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> ((pend_q & en_q & ((NSRC'(1) << pick_idx) - NSRC'(1))) == '0)); // R3
endmodule

// File: rtl/xcs_engine.sv
// Module: activation sequencer. It walks vector, record, data and write-back
// accesses, follows the chain, and decides clear and interrupt from the first
// record. Assumes mem_ack only while mem_req is high and chains stay in range.
module xcs_engine
    import xcs_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                IDX_W    = 5,
    parameter int                SRC_W    = 6,
    parameter logic [ADDR_W-1:0] VEC_BASE = 12'h000,
    parameter logic [ADDR_W-1:0] REC_BASE = 12'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pick_vld,
    input  logic [SRC_W-1:0]  pick_idx,
    output logic              take,
    output logic              clr_vld,
    output logic [SRC_W-1:0]  clr_src,
    output logic              busy,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    xcs_state_e        state_q;
    logic [SRC_W-1:0]  src_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] w0_q, w1_q, dat_q;
    logic              first_q, fire_q, irq_q;

    logic [ADDR_W-1:0] rec_addr;
    logic [7:0]        cnt, new_cnt;
    logic              term, fire_now, fire_end, last;
    logic [DATA_W-1:0] w0_new;

    // Counter update and terminal decision for the current record.
    always_comb begin
        rec_addr = REC_BASE + ADDR_W'({idx_q, 1'b0});
        cnt      = w0_q[CNT_LSB +: 8];
        term     = (cnt == 8'd1);
        if (term) new_cnt = w0_q[F_REPEAT] ? w0_q[RLD_LSB +: 8] : 8'd0;
        else      new_cnt = cnt - 8'd1;
        w0_new   = {w0_q[DATA_W-1:8], new_cnt};
        fire_now = term && (!w0_q[F_REPEAT] || w0_q[F_RPTIRQ]);
        fire_end = first_q ? fire_now : fire_q;
        last     = (state_q == ST_WB) && mem_ack && !w0_q[F_CHAIN];
        take     = (state_q == ST_IDLE) && pick_vld;
        clr_vld  = last && fire_end;
        clr_src  = src_q;
        busy     = (state_q != ST_IDLE);
        irq      = irq_q;
    end

    // Memory request, address and data per state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_VEC: mem_addr = VEC_BASE + ADDR_W'(src_q);
            ST_CD0: mem_addr = rec_addr;
            ST_CD1: mem_addr = rec_addr + ADDR_W'(1);
            ST_DRD: mem_addr = w1_q[ADDR_W-1:0];
            ST_DWR: begin
                mem_we    = 1'b1;
                mem_addr  = w1_q[DST_LSB +: ADDR_W];
                mem_wdata = dat_q;
            end
            ST_WB: begin
                mem_we    = 1'b1;
                mem_addr  = rec_addr;
                mem_wdata = w0_new;
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Sequencer state, captured words and end-of-activation outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            idx_q   <= '0;
            w0_q    <= '0;
            w1_q    <= '0;
            dat_q   <= '0;
            first_q <= 1'b0;
            fire_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (pick_vld) begin
                    src_q   <= pick_idx;
                    first_q <= 1'b1;
                    state_q <= ST_VEC;
                end
                ST_VEC: if (mem_ack) begin
                    idx_q   <= mem_rdata[IDX_W-1:0];
                    state_q <= ST_CD0;
                end
                ST_CD0: if (mem_ack) begin
                    w0_q    <= mem_rdata;
                    state_q <= ST_CD1;
                end
                ST_CD1: if (mem_ack) begin
                    w1_q    <= mem_rdata;
                    state_q <= ST_DRD;
                end
                ST_DRD: if (mem_ack) begin
                    dat_q   <= mem_rdata;
                    state_q <= ST_DWR;
                end
                ST_DWR: if (mem_ack) state_q <= ST_WB;
                ST_WB: if (mem_ack) begin
                    if (first_q) fire_q <= fire_now;
                    first_q <= 1'b0;
                    if (w0_q[F_CHAIN]) begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= ST_CD0;
                    end else begin
                        irq_q   <= fire_end;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_AFTER_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)); // R10
endmodule

// File: rtl/xfer_chain_seq.sv
// Module: top of the interrupt-triggered chained transfer sequencer. It joins
// the source selector and the engine. Assumes no enable bank write while an
// activation is finishing.
module xfer_chain_seq #(
    parameter int          BANKS    = 5,
    parameter int          BANK_W   = 8,
    parameter int          ADDR_W   = 12,
    parameter int          IDX_W    = 5,
    parameter logic [11:0] VEC_BASE = 12'h000,
    parameter logic [11:0] REC_BASE = 12'h040,
    localparam int         NSRC     = BANKS * BANK_W,
    localparam int         SRC_W    = $clog2(NSRC),
    localparam int         BSEL_W   = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BSEL_W-1:0] cfg_bank,
    input  logic [BANK_W-1:0] cfg_data,
    input  logic [NSRC-1:0]   src_req,
    output logic [NSRC-1:0]   en_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              cpu_irq
);
    logic             take, clr_vld, pick_vld;
    logic [SRC_W-1:0] clr_src, pick_idx;

    xcs_src_sel #(.BANKS(BANKS), .BANK_W(BANK_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_data(cfg_data), .src_req(src_req), .take(take),
        .clr_vld(clr_vld), .clr_src(clr_src), .en_q(en_q),
        .pick_vld(pick_vld), .pick_idx(pick_idx)
    );

    xcs_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W),
                 .VEC_BASE(ADDR_W'(VEC_BASE)), .REC_BASE(ADDR_W'(REC_BASE))) u_eng (
        .clk(clk), .rst_n(rst_n), .pick_vld(pick_vld), .pick_idx(pick_idx),
        .take(take), .clr_vld(clr_vld), .clr_src(clr_src), .busy(busy),
        .irq(cpu_irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !$past(cfg_we)) |-> !en_q[clr_src]); // R7
endmodule

// File: tb/xfer_chain_seq_bench.sv
// Bench: behavioural memory with rotating acknowledge latency, and a reference
// model built from queues of expected writes and outcomes, compared every clock.
module xfer_chain_seq_bench;
    localparam int VEC = 'h000;
    localparam int REC = 'h040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [7:0]  cfg_data = '0;
    logic [39:0] src_req = '0;
    logic [39:0] en_q;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        busy, cpu_irq;

    xfer_chain_seq u_xfer_chain_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_data(cfg_data), .src_req(src_req), .en_q(en_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .cpu_irq(cpu_irq)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    logic [31:0] mem [0:511];
    logic [31:0] ref_mem [0:511];
    int          exp_addr [$];
    logic [31:0] exp_data [$];
    string       exp_tag [$];
    bit          exp_fire [$];
    int          exp_src [$];
    string       fire_tag [$];
    logic [39:0] exp_en = '0;
    bit          prev_busy = 0, waiting = 0, monitor_on = 0;
    logic [11:0] held_addr;
    int          lat_cnt = 0, lat_tgt = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic poke(input int a, input logic [31:0] d);
        mem[a] = d;
        ref_mem[a] = d;
    endtask

    task automatic bank_write(input int b, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(b); cfg_data = d;
        @(posedge clk); #1;
        exp_en[b*8 +: 8] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic enable_src(input int s);
        logic [7:0] v;
        v = exp_en[(s/8)*8 +: 8] | (8'd1 << (s % 8));
        bank_write(s / 8, v);
    endtask

    // Reference model of one activation from the requirements.
    task automatic model_act(input int s);
        logic [31:0] w0, w1, d, nw0;
        logic [7:0]  c, nc;
        int i, a, dst;
        bit first, fire, term;
        i = int'(ref_mem[VEC + s][4:0]);
        first = 1; fire = 0;
        do begin
            a = REC + 2 * i;
            w0 = ref_mem[a]; w1 = ref_mem[a + 1];
            d = ref_mem[w1[8:0]];
            dst = int'(w1[24:16]);
            ref_mem[dst] = d;
            exp_addr.push_back(dst); exp_data.push_back(d); exp_tag.push_back("R4");
            c = w0[7:0];
            term = (c == 8'd1);
            nc = term ? (w0[29] ? w0[15:8] : 8'd0) : c - 8'd1;
            nw0 = {w0[31:8], nc};
            ref_mem[a] = nw0;
            exp_addr.push_back(a); exp_data.push_back(nw0); exp_tag.push_back("R6");
            if (first) fire = term && (!w0[29] || w0[30]);
            first = 0;
            i++;
        end while (w0[31]);
        exp_fire.push_back(fire);
        exp_src.push_back(s);
        fire_tag.push_back(fire ? "R7" : "R8_R9");
    endtask

    task automatic pulse(input logic [39:0] m);
        @(negedge clk); src_req = m;
        @(negedge clk); src_req = '0;
    endtask

    task automatic wait_done();
        repeat (4) @(negedge clk);
        while (busy || exp_fire.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Memory responder, handshake check, per-clock outcome comparison, watchdog.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
        if (!rst_n) begin
            mem_ack = 1'b0; lat_cnt = 0; waiting = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; waiting = 0;
        end else if (mem_req) begin
            if (waiting) check(mem_addr == held_addr, "R10 address hold", mem_addr, held_addr);
            if (lat_cnt >= lat_tgt) begin
                mem_ack = 1'b1; waiting = 0;
                if (mem_we) begin
                    if (exp_addr.size() == 0) begin
                        check(0, "R2 unexpected write", mem_addr, 0);
                    end else begin
                        check(int'(mem_addr) == exp_addr[0], exp_tag[0], mem_addr, exp_addr[0]);
                        check(mem_wdata == exp_data[0], exp_tag[0], mem_wdata, exp_data[0]);
                        void'(exp_addr.pop_front()); void'(exp_data.pop_front()); void'(exp_tag.pop_front());
                    end
                    mem[mem_addr[8:0]] = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[8:0]];
                end
                lat_cnt = 0; lat_tgt = (lat_tgt + 1) % 3;
            end else begin
                waiting = 1; held_addr = mem_addr; lat_cnt++;
            end
        end
        if (monitor_on) begin
            if (prev_busy && !busy) begin
                if (exp_fire.size() == 0) begin
                    check(0, "R5 extra activation end", 1, 0);
                end else begin
                    check(cpu_irq == exp_fire[0], fire_tag[0], cpu_irq, exp_fire[0]);
                    if (exp_fire[0]) exp_en[exp_src[0]] = 1'b0;
                    void'(exp_fire.pop_front()); void'(exp_src.pop_front()); void'(fire_tag.pop_front());
                end
            end else if (cpu_irq) begin
                check(0, "R9 stray interrupt", 1, 0);
            end
            check(en_q == exp_en, "R1_R7 enables", en_q, exp_en);
        end
        prev_busy = busy;
    end

    initial begin
        for (int k = 0; k < 512; k++) poke(k, 32'h0);
        for (int k = 0; k < 32; k++) poke('h100 + k, 32'hD000_0000 + 32'(k * 17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(en_q == '0, "R1 reset enables", en_q, 0);
        check(!busy && !cpu_irq && !mem_req, "R1 reset outputs", {busy, cpu_irq, mem_req}, 0);
        monitor_on = 1;

        // normal record, count 3 -> 2 -> 1 -> 0 with interrupt
        poke(VEC + 5, 32'd2);
        poke(REC + 4, 32'h0000_0003);
        poke(REC + 5, {16'h0180, 16'h0100});
        pulse(40'd1 << 5);
        repeat (20) @(negedge clk);
        check(!busy && exp_addr.size() == 0, "R2 disabled source ignored", busy, 0);
        enable_src(5);
        for (int n = 0; n < 3; n++) begin
            model_act(5); pulse(40'd1 << 5); wait_done();
        end
        check(mem[REC + 4] == 32'h0, "R6 counter at zero", mem[REC + 4], 0);
        check(en_q[5] == 1'b0, "R7 enable cleared", en_q[5], 0);
        pulse(40'd1 << 5);
        repeat (20) @(negedge clk);
        check(!busy, "R2 cleared source ignored", busy, 0);

        // repeat mode without interrupt enable: reload, no clear
        poke(VEC + 9, 32'd6);
        poke(REC + 12, 32'h2000_0401);
        poke(REC + 13, {16'h0181, 16'h0101});
        enable_src(9);
        model_act(9); pulse(40'd1 << 9); wait_done();
        check(mem[REC + 12] == 32'h2000_0404, "R8 reload without irq", mem[REC + 12], 32'h2000_0404);
        check(en_q[9] == 1'b1, "R8 enable kept", en_q[9], 1);

        // repeat mode with interrupt enable
        poke(VEC + 10, 32'd7);
        poke(REC + 14, 32'h6000_0501);
        poke(REC + 15, {16'h0182, 16'h0102});
        enable_src(10);
        model_act(10); pulse(40'd1 << 10); wait_done();
        check(en_q[10] == 1'b0, "R8 enable cleared", en_q[10], 0);

        // chain whose second record terminates: no interrupt
        poke(VEC + 12, 32'd10);
        poke(REC + 20, 32'h8000_0005);
        poke(REC + 21, {16'h0183, 16'h0103});
        poke(REC + 22, 32'h0000_0001);
        poke(REC + 23, {16'h0184, 16'h0104});
        enable_src(12);
        model_act(12); pulse(40'd1 << 12); wait_done();
        check(en_q[12] == 1'b1, "R9 chained terminal ignored", en_q[12], 1);
        check(mem[REC + 22] == 32'h0, "R5 chained record updated", mem[REC + 22], 0);

        // chain whose first record terminates: interrupt after the chain
        poke(VEC + 13, 32'd14);
        poke(REC + 28, 32'h8000_0001);
        poke(REC + 29, {16'h0185, 16'h0105});
        poke(REC + 30, 32'h0000_0007);
        poke(REC + 31, {16'h0186, 16'h0106});
        enable_src(13);
        model_act(13); pulse(40'd1 << 13); wait_done();
        check(mem[REC + 30] == 32'h6, "R5 second record written", mem[REC + 30], 6);

        // priority among simultaneous requests
        poke(VEC + 3, 32'd18);  poke(REC + 36, 32'h9); poke(REC + 37, {16'h0187, 16'h0107});
        poke(VEC + 7, 32'd19);  poke(REC + 38, 32'h9); poke(REC + 39, {16'h0188, 16'h0108});
        poke(VEC + 39, 32'd20); poke(REC + 40, 32'h9); poke(REC + 41, {16'h0189, 16'h0109});
        enable_src(3); enable_src(7); enable_src(39);
        model_act(3); model_act(7); model_act(39);
        pulse((40'd1 << 39) | (40'd1 << 7) | (40'd1 << 3));
        wait_done();
        check(exp_addr.size() == 0, "R3 all serviced in order", exp_addr.size(), 0);

        // zero counter wraps to 255 without interrupt
        poke(VEC + 20, 32'd22);
        poke(REC + 44, 32'h0);
        poke(REC + 45, {16'h018A, 16'h010A});
        enable_src(20);
        model_act(20); pulse(40'd1 << 20); wait_done();
        check(mem[REC + 44] == 32'hFF, "R6 wrap from zero", mem[REC + 44], 32'hFF);

        // direct bank load
        bank_write(4, 8'hA5);
        @(negedge clk);
        check(en_q[39:32] == 8'hA5, "R1 bank load", en_q[39:32], 8'hA5);

        check(exp_addr.size() == 0 && exp_fire.size() == 0, "R4 queues drained",
              exp_addr.size() + exp_fire.size(), 0);
        finish_run();
    end
endmodule